// File: doc/BRIEF.md
# Serial Port with Bus Register Interface and Interrupts

This block is a byte-wide asynchronous serial port reached through a zero-wait-state APB slave. Software writes one byte into a holding register. A transmit engine hands that byte to a shift register and sends it as a frame with a start bit, eight data bits LSB first and one stop bit. A receive engine recovers incoming frames into a one-byte receive register. Each direction has a full flag and an overrun flag. The bit period is set by a 20-bit divider counted in bus clock cycles.

Interrupts are reported in two ways. Transmit-done and receive-done are sticky event bits that software clears by writing 1. The two overrun interrupt bits are not stored: each is the live overrun flag gated by its enable. Five interrupt lines leave the block: one per source, plus a combined line. Twelve read-only identification words occupy the top of the 4 KB address window.

Top module: `sercom_apb`

## Requirements
- R1: Registers are decoded on address bits [11:2]. The data register is at 0x00, status at 0x04, control at 0x08, interrupt status at 0x0C and divider at 0x10. Any offset that is not decoded reads as zero and ignores writes. `pready` is always 1, so each access completes in its access phase.
- R2: Offsets 0xFD0–0xFFC read one identification byte each, in bits [7:0] with upper bits zero. The bytes are 04,00,00,00 at 0xFD0–0xFDC; 3C,91,1A,00 at 0xFE0–0xFEC; and 0D,F0,05,B1 at 0xFF0–0xFFC. Writes to these offsets change nothing.
- R3: Control keeps only bits [6:0]: bit0 transmit enable, bit1 receive enable, bit2 transmit interrupt enable, bit3 receive interrupt enable, bit4 transmit-overrun interrupt enable, bit5 receive-overrun interrupt enable, bit6 stored with no function. The divider keeps only bits [19:0].
- R4: Status bits are: bit0 transmit full, bit1 receive full, bit2 transmit overrun, bit3 receive overrun. A data write while transmit full is clear stores the byte and sets transmit full. A data write while transmit full is set only sets transmit overrun and leaves the stored byte unchanged.
- R5: The transmitter starts a frame one cycle after transmit enable, transmit full and a valid divider all hold. The frame is a low start bit, 8 data bits LSB first and a high stop bit, each lasting divider cycles. At the hand-off, transmit full clears, and interrupt status bit0 sets if bit2 of control is 1.
- R6: While receive enable is 1, a frame whose start bit is still low at half a bit and whose stop bit is high sets receive full. It also sets interrupt status bit1 if bit3 of control is 1. While receive enable is 0, incoming frames change nothing.
- R7: A frame that arrives while receive full is set sets receive overrun, and the new byte replaces the old one.
- R8: A read of the data register returns the received byte in bits [7:0] and clears receive full.
- R9: Interrupt status bits 0 and 1 are sticky and clear on a write of 1. Bit 2 reads as transmit overrun AND control bit4. Bit 3 reads as receive overrun AND control bit5.
- R10: Writing 1 to bit 2 or bit 3 of either the status register or the interrupt status register clears the matching overrun flag. No write changes the full flags.
- R11: `irq_tx`, `irq_rx`, `irq_txov` and `irq_rxov` follow interrupt status bits 0–3. `irq_any` is 1 when any of those bits is 1.
- R12: A divider value below 16 is invalid. While it is invalid, no transmit frame starts, `txd` stays high and transmit full stays set.
- R13: After reset, status, control, interrupt status, divider and both byte buffers are zero, `txd` is high and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and serial clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive-done interrupt |
| irq_txov | output | 1 | Transmit overrun interrupt |
| irq_rxov | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of all four interrupts |

## Verification
The properties assume that the bus master never writes the data register in the same cycle as another register. They also assume that a receive frame never completes in the same cycle as a data read or an interrupt-status clear. Without those rules, the "set wins" and "clear wins" orderings would make the overrun and full checks ambiguous. The bench makes one bus access at a time. It drives serial frames on `rxd` only between bus accesses that touch the receive path, and reads the data register only after a frame's stop bit has finished. It waits for the transmitter to go idle before it changes the divider.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  localparam int CTRL_W = 7;
  localparam int C_TXEN  = 0;
  localparam int C_RXEN  = 1;
  localparam int C_TXIE  = 2;
  localparam int C_RXIE  = 3;
  localparam int C_TXOIE = 4;
  localparam int C_RXOIE = 5;

  localparam logic [9:0] W_DATA  = 10'h000;
  localparam logic [9:0] W_STATE = 10'h001;
  localparam logic [9:0] W_CTRL  = 10'h002;
  localparam logic [9:0] W_INT   = 10'h003;
  localparam logic [9:0] W_DIV   = 10'h004;
  localparam logic [9:0] W_ID_LO = 10'h3F4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  function automatic logic [7:0] id_byte(input logic [9:0] word);
    case (word)
      10'h3F4: id_byte = 8'h04;
      10'h3F8: id_byte = 8'h3C;
      10'h3F9: id_byte = 8'h91;
      10'h3FA: id_byte = 8'h1A;
      10'h3FC: id_byte = 8'h0D;
      10'h3FD: id_byte = 8'hF0;
      10'h3FE: id_byte = 8'h05;
      10'h3FF: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sercom_regs.sv
module sercom_regs
  import sercom_pkg::*;
#(
  parameter int DIV_W   = 20,
  parameter int DATA_W  = 8,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [11:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tx_take,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_go,
  output logic              rx_on,
  output logic [DIV_W-1:0]  div,
  output logic              div_ok,
  output logic [3:0]        status,
  output logic [3:0]        intstat
);
  logic [9:0]        word;
  logic [DATA_W-1:0] txbuf_q, txbuf_n, rxbuf_q, rxbuf_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic txfull_q, txfull_n, rxfull_q, rxfull_n;
  logic txov_q, txov_n, rxov_q, rxov_n;
  logic itx_q, itx_n, irx_q, irx_n;
  logic unused_ok;

  assign word      = addr[11:2];
  assign unused_ok = ^{addr[1:0], wdata[31:20]};

  assign div     = div_q;
  assign div_ok  = div_q >= DIV_W'(MIN_DIV);
  assign tx_byte = txbuf_q;
  assign tx_go   = ctrl_q[C_TXEN] & txfull_q & div_ok;
  assign rx_on   = ctrl_q[C_RXEN] & div_ok;
  assign status  = {rxov_q, txov_q, rxfull_q, txfull_q};
  assign intstat = {rxov_q & ctrl_q[C_RXOIE], txov_q & ctrl_q[C_TXOIE], irx_q, itx_q};

  always_comb begin
    txbuf_n = txbuf_q; rxbuf_n = rxbuf_q; ctrl_n = ctrl_q; div_n = div_q;
    txfull_n = txfull_q; rxfull_n = rxfull_q;
    txov_n = txov_q; rxov_n = rxov_q; itx_n = itx_q; irx_n = irx_q;
    // clearing writes first, events afterwards so that events win
    if (wr_en) begin
      case (word)
        W_STATE: begin
          if (wdata[2]) txov_n = 1'b0;
          if (wdata[3]) rxov_n = 1'b0;
        end
        W_INT: begin
          if (wdata[0]) itx_n = 1'b0;
          if (wdata[1]) irx_n = 1'b0;
          if (wdata[2]) txov_n = 1'b0;
          if (wdata[3]) rxov_n = 1'b0;
        end
        W_CTRL: ctrl_n = wdata[CTRL_W-1:0];
        W_DIV:  div_n  = wdata[DIV_W-1:0];
        W_DATA: begin
          if (txfull_q) txov_n = 1'b1;
          else begin
            txbuf_n  = wdata[DATA_W-1:0];
            txfull_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (rd_en && word == W_DATA) rxfull_n = 1'b0;
    if (tx_take) begin
      txfull_n = 1'b0;
      if (ctrl_q[C_TXIE]) itx_n = 1'b1;
    end
    if (rx_valid && ctrl_q[C_RXEN]) begin
      if (rxfull_q) rxov_n = 1'b1;
      rxbuf_n  = rx_byte;
      rxfull_n = 1'b1;
      if (ctrl_q[C_RXIE]) irx_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf_q <= '0; rxbuf_q <= '0; ctrl_q <= '0; div_q <= '0;
      txfull_q <= 1'b0; rxfull_q <= 1'b0; txov_q <= 1'b0; rxov_q <= 1'b0;
      itx_q <= 1'b0; irx_q <= 1'b0;
    end else begin
      txbuf_q <= txbuf_n; rxbuf_q <= rxbuf_n; ctrl_q <= ctrl_n; div_q <= div_n;
      txfull_q <= txfull_n; rxfull_q <= rxfull_n; txov_q <= txov_n; rxov_q <= rxov_n;
      itx_q <= itx_n; irx_q <= irx_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (word == W_DATA)       rdata[DATA_W-1:0] = rxbuf_q;
    else if (word == W_STATE) rdata[3:0] = status;
    else if (word == W_CTRL)  rdata[CTRL_W-1:0] = ctrl_q;
    else if (word == W_INT)   rdata[3:0] = intstat;
    else if (word == W_DIV)   rdata[DIV_W-1:0] = div_q;
    else if (word >= W_ID_LO) rdata[7:0] = id_byte(word);
  end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DIV_W-1:0]  div,
  output logic              take,
  output logic              txd
);
  localparam int FW = DATA_W + 2;
  localparam int NW = $clog2(FW);

  logic          busy_q, busy_n;
  logic [FW-1:0] sh_q, sh_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [NW-1:0] n_q, n_n;

  assign txd = sh_q[0];

  always_comb begin
    take = 1'b0;
    busy_n = busy_q; sh_n = sh_q; cnt_n = cnt_q; n_n = n_q;
    if (!busy_q) begin
      if (go) begin
        take   = 1'b1;
        busy_n = 1'b1;
        sh_n   = {1'b1, byte_in, 1'b0};
        cnt_n  = div - DIV_W'(1);
        n_n    = '0;
      end
    end else if (cnt_q == '0) begin
      sh_n  = {1'b1, sh_q[FW-1:1]};
      cnt_n = div - DIV_W'(1);
      if (n_q == NW'(FW-1)) busy_n = 1'b0;
      else n_n = n_q + NW'(1);
    end else begin
      cnt_n = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sh_q <= '1; cnt_q <= '0; n_q <= '0;
    end else begin
      busy_q <= busy_n; sh_q <= sh_n; cnt_q <= cnt_n; n_q <= n_n;
    end
  end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  div,
  output logic              valid,
  output logic [DATA_W-1:0] byte_out
);
  localparam int IW = $clog2(DATA_W);

  logic s1_q, s2_q, s3_q;
  rx_st_e st_q, st_n;
  logic [DIV_W-1:0]  cnt_q, cnt_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;

  assign byte_out = sh_q;

  always_comb begin
    valid = 1'b0;
    st_n = st_q; cnt_n = cnt_q; idx_n = idx_q; sh_n = sh_q;
    if (!en) begin
      st_n = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: if (s3_q && !s2_q) begin
          st_n  = RX_START;
          cnt_n = div >> 1;
        end
        RX_START: if (cnt_q == '0) begin
          if (!s2_q) begin
            st_n  = RX_DATA;
            cnt_n = div - DIV_W'(1);
            idx_n = '0;
          end else st_n = RX_IDLE;
        end else cnt_n = cnt_q - DIV_W'(1);
        RX_DATA: if (cnt_q == '0) begin
          sh_n  = {s2_q, sh_q[DATA_W-1:1]};
          cnt_n = div - DIV_W'(1);
          if (idx_q == IW'(DATA_W-1)) st_n = RX_STOP;
          else idx_n = idx_q + IW'(1);
        end else cnt_n = cnt_q - DIV_W'(1);
        RX_STOP: if (cnt_q == '0) begin
          valid = s2_q;
          st_n  = RX_IDLE;
        end else cnt_n = cnt_q - DIV_W'(1);
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1;
      st_q <= RX_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
    end else begin
      s1_q <= rxd; s2_q <= s1_q; s3_q <= s2_q;
      st_q <= st_n; cnt_q <= cnt_n; idx_q <= idx_n; sh_q <= sh_n;
    end
  end
endmodule

// File: rtl/sercom_apb.sv
module sercom_apb #(
  parameter int DIV_W   = 20,
  parameter int DATA_W  = 8,
  parameter int MIN_DIV = 16
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_txov,
  output logic        irq_rxov,
  output logic        irq_any
);
  logic rst_a_q, rst_n;
  logic wr_en, rd_en;
  logic tx_take, tx_go, rx_valid, rx_on, div_ok;
  logic [DATA_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  div;
  logic [3:0] status, intstat;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_a_q <= 1'b0; rst_n <= 1'b0;
    end else begin
      rst_a_q <= 1'b1; rst_n <= rst_a_q;
    end
  end

  assign wr_en  = psel & penable & pwrite;
  assign rd_en  = psel & penable & ~pwrite;
  assign pready = 1'b1;

  sercom_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .MIN_DIV(MIN_DIV)) u_regs (
    .clk(pclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(paddr),
    .wdata(pwdata), .rdata(prdata), .tx_take(tx_take), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .tx_go(tx_go), .rx_on(rx_on),
    .div(div), .div_ok(div_ok), .status(status), .intstat(intstat)
  );

  sercom_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(pclk), .rst_n(rst_n), .go(tx_go), .byte_in(tx_byte), .div(div),
    .take(tx_take), .txd(txd)
  );

  sercom_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(pclk), .rst_n(rst_n), .en(rx_on), .rxd(rxd), .div(div),
    .valid(rx_valid), .byte_out(rx_byte)
  );

  assign irq_tx   = intstat[0];
  assign irq_rx   = intstat[1];
  assign irq_txov = intstat[2];
  assign irq_rxov = intstat[3];
  assign irq_any  = |intstat;
endmodule

// File: rtl/sercom_chk.sv
module sercom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [9:0] word,
  input logic       tx_take,
  input logic       rx_valid,
  input logic       rx_on,
  input logic       div_ok,
  input logic [3:0] status,
  input logic       irq_txov,
  input logic       irq_rxov
);
  a_r4_full_write_overruns: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 10'h000 && status[0]) |=> status[2]);
  a_r5_handoff_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !status[0]);
  a_r6_frame_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_on) |=> status[1]);
  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == 10'h000 && !rx_valid) |=> !status[1]);
  a_r9_txo_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txov |-> status[2]);
  a_r9_rxo_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxov |-> status[3]);
  a_r12_no_start_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok |-> !tx_take);
endmodule

bind sercom_apb sercom_chk u_chk (
  .clk(pclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .word(paddr[11:2]),
  .tx_take(tx_take), .rx_valid(rx_valid), .rx_on(rx_on), .div_ok(div_ok),
  .status(status), .irq_txov(irq_txov), .irq_rxov(irq_rxov)
);

// File: tb/sercom_apb_test.sv
module sercom_apb_test;
  logic clk = 1'b0;
  logic presetn, psel, penable, pwrite, rxd;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic pready, txd, irq_tx, irq_rx, irq_txov, irq_rxov, irq_any;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  logic [31:0] got;

  always #4 clk = ~clk;

  sercom_apb uut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .rxd(rxd),
    .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txov(irq_txov),
    .irq_rxov(irq_rxov), .irq_any(irq_any)
  );

  function automatic logic [7:0] exp_id(input int i);
    case (i)
      0: exp_id = 8'h04; 4: exp_id = 8'h3C; 5: exp_id = 8'h91; 6: exp_id = 8'h1A;
      8: exp_id = 8'h0D; 9: exp_id = 8'hF0; 10: exp_id = 8'h05; 11: exp_id = 8'hB1;
      default: exp_id = 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #2 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic send_rx(input logic [7:0] b, input int div);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      repeat (div) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cap_tx(input int div, output logic [31:0] b);
    int t;
    t = 0;
    b = 32'h0;
    while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    if (t >= 4000) begin b = 32'hDEAD; return; end
    repeat (div / 2) @(negedge clk);
    if (txd !== 1'b0) b[8] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (div) @(negedge clk);
      b[i] = txd;
    end
    repeat (div) @(negedge clk);
    if (txd !== 1'b1) b[9] = 1'b1;
    repeat (div / 2 + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic stayed_high;
    logic [7:0] b, b2;
    int dv;
    void'($urandom(32'd1357));
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; rxd = 1;
    repeat (5) @(negedge clk);
    presetn = 1;
    repeat (4) @(negedge clk);

    // R13 reset state
    apb_rd(12'h004, rv); chk("R13 status", rv, 0);
    apb_rd(12'h008, rv); chk("R13 ctrl", rv, 0);
    apb_rd(12'h00C, rv); chk("R13 intstat", rv, 0);
    apb_rd(12'h010, rv); chk("R13 div", rv, 0);
    apb_rd(12'h000, rv); chk("R13 rxbuf", rv, 0);
    chk("R13 lines", {txd, irq_any, irq_tx, irq_rx, irq_txov, irq_rxov}, 6'b100000);

    // R1 undecoded offsets and ready
    apb_wr(12'h014, 32'hFFFF_FFFF);
    apb_rd(12'h014, rv); chk("R1 hole 0x014", rv, 0);
    apb_rd(12'h800, rv); chk("R1 hole 0x800", rv, 0);
    chk("R1 pready", {31'b0, pready}, 1);

    // R2 identification words
    for (int i = 0; i < 12; i++) begin
      apb_rd(12'hFD0 + 12'(i * 4), rv); chk("R2 id", rv, {24'b0, exp_id(i)});
    end
    apb_wr(12'hFE0, 32'hFF);
    apb_rd(12'hFE0, rv); chk("R2 id write ignored", rv, 32'h3C);

    // R3 field widths
    apb_wr(12'h008, 32'hFFFF_FFFF);
    apb_rd(12'h008, rv); chk("R3 ctrl mask", rv, 32'h7F);
    apb_wr(12'h008, 32'h0);
    apb_wr(12'h010, 32'hFFFF_FFFF);
    apb_rd(12'h010, rv); chk("R3 div mask", rv, 32'hFFFFF);

    // R12 invalid divider blocks transmission
    apb_wr(12'h010, 32'd8);
    apb_wr(12'h008, 32'h01);
    apb_wr(12'h000, 32'h5A);
    stayed_high = 1;
    repeat (200) begin @(negedge clk); if (txd !== 1'b1) stayed_high = 0; end
    chk("R12 txd idle", {31'b0, stayed_high}, 1);
    apb_rd(12'h004, rv); chk("R12 still full", rv, 32'h1);

    // R4 overrun on full write, R9/R11 overrun interrupt
    apb_wr(12'h000, 32'h33);
    apb_rd(12'h004, rv); chk("R4 overrun", rv, 32'h5);
    apb_rd(12'h00C, rv); chk("R9 txo gated off", rv, 0);
    apb_wr(12'h008, 32'h11);
    apb_rd(12'h00C, rv); chk("R9 txo level", rv, 32'h4);
    chk("R11 txov line", {30'b0, irq_txov, irq_any}, 32'h3);
    apb_wr(12'h004, 32'h7);
    apb_rd(12'h004, rv); chk("R10 status clear keeps full", rv, 32'h1);
    chk("R11 txov low", {31'b0, irq_txov}, 0);
    apb_wr(12'h000, 32'h44);
    apb_wr(12'h00C, 32'h4);
    apb_rd(12'h004, rv); chk("R10 intstat clear", rv, 32'h1);

    // R5 first byte leaves once divider valid
    apb_wr(12'h008, 32'h05);
    fork
      apb_wr(12'h010, 32'd16);
      cap_tx(16, got);
    join
    chk("R5 frame byte", got, 32'h5A);
    apb_rd(12'h004, rv); chk("R5 full cleared", rv, 0);
    apb_rd(12'h00C, rv); chk("R5 tx int", rv, 32'h1);
    chk("R11 tx line", {30'b0, irq_tx, irq_any}, 32'h3);
    apb_wr(12'h00C, 32'h1);
    apb_rd(12'h00C, rv); chk("R9 tx sticky cleared", rv, 0);

    // R5 random transmit
    for (int k = 0; k < 12; k++) begin
      dv = 16 + int'($urandom % 16);
      b = 8'($urandom);
      apb_wr(12'h010, 32'(dv));
      fork
        apb_wr(12'h000, {24'b0, b});
        cap_tx(dv, got);
      join
      chk("R5 random tx", got, {24'b0, b});
    end
    apb_wr(12'h00C, 32'h1);

    // R6 / R8 receive
    apb_wr(12'h010, 32'd20);
    apb_wr(12'h008, 32'h0A);
    send_rx(8'hA5, 20);
    apb_rd(12'h004, rv); chk("R6 rx full", rv, 32'h2);
    chk("R11 rx line", {30'b0, irq_rx, irq_any}, 32'h3);
    apb_rd(12'h000, rv); chk("R8 rx byte", rv, 32'hA5);
    apb_rd(12'h004, rv); chk("R8 full cleared", rv, 0);
    apb_rd(12'h00C, rv); chk("R6 rx int", rv, 32'h2);
    apb_wr(12'h00C, 32'h2);
    apb_rd(12'h00C, rv); chk("R9 rx sticky cleared", rv, 0);

    // R7 receive overrun
    apb_wr(12'h008, 32'h2A);
    send_rx(8'h11, 20);
    send_rx(8'h22, 20);
    apb_rd(12'h004, rv); chk("R7 overrun flags", rv, 32'hA);
    chk("R7 rxov line", {31'b0, irq_rxov}, 1);
    apb_rd(12'h000, rv); chk("R7 newest byte", rv, 32'h22);
    apb_wr(12'h004, 32'h8);
    apb_rd(12'h004, rv); chk("R10 rx overrun clear", rv, 0);
    chk("R7 rxov line low", {31'b0, irq_rxov}, 0);
    apb_wr(12'h00C, 32'h2);

    // R6 disabled receiver ignores frames
    apb_wr(12'h008, 32'h0);
    send_rx(8'h77, 20);
    apb_rd(12'h004, rv); chk("R6 ignored full", rv, 0);
    apb_rd(12'h000, rv); chk("R6 ignored buffer", rv, 32'h22);

    // R6 random receive
    apb_wr(12'h008, 32'h02);
    for (int k = 0; k < 12; k++) begin
      dv = 16 + int'($urandom % 24);
      b2 = 8'($urandom);
      apb_wr(12'h010, 32'(dv));
      send_rx(b2, dv);
      apb_rd(12'h000, rv); chk("R6 random rx", rv, {24'b0, b2});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule